// File: doc/BRIEF.md
# RMII Transmit Serializer with Low-Power Idle

This block sits between a MAC's byte-wide transmit stream and the two-bit RMII transmit pins. It runs on the 50 MHz reference clock and turns each accepted byte into four dibits on `txd`, raising `tx_en` while frame data is on the lines. A slow-rate input stretches every dibit over ten reference clocks for 10 Mb/s links. Preamble, FCS, flow control and clock generation are handled elsewhere.

The byte side is a valid/ready handshake with start-of-frame and end-of-frame flags. Bytes follow one another with no gap while a frame is open. A frame closes when its end-of-frame byte has been sent, or when the next byte is missing at the moment it is needed.

A sideband level, `lpi_req`, asks for Energy Efficient Ethernet low-power idle. While the transmitter is in that state it holds a distinct code on the idle lines. When the request drops, it restores the normal idle code and then waits a programmable number of clocks before a new frame may start. Frame requests made during low-power idle or during that wait are held off through `s_ready`.

Top module: `rmii_lpi_tx`

## Requirements
- R1: After reset `tx_en` is 0, `txd` is 2'b00 and `s_ready` is 1.
- R2: At full rate (`speed_slow`=0) a byte accepted at a clock edge appears on `txd` from that edge for four clocks, bits [1:0] first and bits [7:6] last, with `txd[0]` carrying the lower bit of each pair; `tx_en` is 1 for those clocks.
- R3: With `speed_slow`=1 each dibit is held on `txd` for ten consecutive clocks, so one byte takes forty clocks.
- R4: While a frame is open and its end byte has not been taken, `s_ready` is 1 only in the final clock of the current byte; a byte accepted there follows with no gap, and its `s_sof` is ignored.
- R5: One clock after the last dibit of a frame, `tx_en` is 0 and `txd` is 2'b00. This happens after the byte flagged `s_eof`, and also when no byte is offered in the final clock of a byte (underrun).
- R6: While idle, a byte offered without `s_sof` is consumed (`s_ready`=1) and leaves `tx_en` at 0 and `txd` at 2'b00.
- R7: With `lpi_req`=1 and no byte offered, low-power idle (`tx_en`=0, `txd`=2'b01) begins only after the line has shown the idle code for at least one clock. It never begins directly from a clock with `tx_en`=1.
- R8: When `lpi_req` falls during low-power idle, `txd` returns to 2'b00 at the next edge. `s_ready` then stays 0 for `wake_cycles` further clocks (a value of 0 acts as 1), so `tx_en` cannot rise in the clock that follows low-power idle.
- R9: `s_ready` is 0 during low-power idle and during the wake wait; a frame offered then waits without being lost.
- R10: While idle, a byte with `s_sof` offered together with `lpi_req` starts the frame rather than low-power idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz RMII reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_slow | input | 1 | 1 selects 10 Mb/s dibit stretching; change only between frames |
| wake_cycles | input | WAKE_W | Clocks to wait after leaving low-power idle |
| lpi_req | input | 1 | Level request for low-power idle |
| s_valid | input | 1 | Byte offered |
| s_data | input | 8 | Byte to send |
| s_sof | input | 1 | Byte opens a frame |
| s_eof | input | 1 | Byte closes the frame |
| s_ready | output | 1 | Byte taken at this edge when `s_valid` is 1 |
| txd | output | 2 | RMII transmit dibit |
| tx_en | output | 1 | RMII transmit enable |

## Verification
The bench targets the handoff between bytes. If the ready window were off by a clock, it would either duplicate a dibit or cut the fourth one short. It also holds back a byte so that the frame underruns; a design that stalled there would keep `tx_en` high on stale data. Low-power idle is requested during a frame, at the exact cycle a frame ends, and together with a new start-of-frame byte. This catches entry straight out of a frame or entry that wins over waiting data. Frames are also offered during low-power idle with wake counts of 5 and 0, so an off-by-one wait or a zero count that skips the wait shows up as `tx_en` rising early.

// File: rtl/rmii_lpi_pkg.sv
package rmii_lpi_pkg;
    localparam int BYTE_W = 8;
    localparam int DIBITS = BYTE_W / 2;
    localparam int IDX_W  = $clog2(DIBITS);

    localparam logic [1:0] TXD_IDLE = 2'b00;
    localparam logic [1:0] TXD_LPI  = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_LPI,
        ST_WAKE
    } tx_state_e;

    typedef struct packed {
        tx_state_e          st;
        logic [BYTE_W-1:0]  shf;
        logic [IDX_W-1:0]   idx;
        logic               eof;
        logic               idle_ok;
        logic               en;
        logic [1:0]         txd;
    } tx_regs_t;
endpackage

// File: rtl/rmii_dibit_pacer.sv
module rmii_dibit_pacer #(
    parameter int HOLD = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = slow ? CNT_W'(HOLD - 1) : '0;
        tick  = (cnt_q == limit);
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rmii_wake_timer.sv
module rmii_wake_timer #(
    parameter int WAKE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAKE_W-1:0] wake_cycles,
    output logic              done
);
    logic [WAKE_W-1:0] cnt_d, cnt_q;
    logic [WAKE_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        done    = (cnt_inc >= {1'b0, wake_cycles});
        if (!run)      cnt_d = '0;
        else if (done) cnt_d = cnt_q;
        else           cnt_d = cnt_inc[WAKE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rmii_lpi_tx.sv
module rmii_lpi_tx
    import rmii_lpi_pkg::*;
#(
    parameter int SLOW_HOLD = 10,
    parameter int WAKE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_slow,
    input  logic [WAKE_W-1:0] wake_cycles,
    input  logic              lpi_req,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_sof,
    input  logic              s_eof,
    output logic              s_ready,
    output logic [1:0]        txd,
    output logic              tx_en
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIBITS - 1);

    tx_regs_t cur_q, nxt_d;
    logic     tick;
    logic     wake_done;
    logic     last_dibit;

    rmii_dibit_pacer #(.HOLD(SLOW_HOLD)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cur_q.st == ST_SEND),
        .slow  (speed_slow),
        .tick  (tick)
    );

    rmii_wake_timer #(.WAKE_W(WAKE_W)) u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (cur_q.st == ST_WAKE),
        .wake_cycles (wake_cycles),
        .done        (wake_done)
    );

    always_comb begin
        nxt_d      = cur_q;
        s_ready    = 1'b0;
        last_dibit = (cur_q.idx == IDX_LAST);
        case (cur_q.st)
            ST_IDLE: begin
                s_ready = 1'b1;
                if (s_valid && s_sof) begin
                    nxt_d.st  = ST_SEND;
                    nxt_d.shf = s_data;
                    nxt_d.idx = '0;
                    nxt_d.eof = s_eof;
                    nxt_d.en  = 1'b1;
                    nxt_d.txd = s_data[1:0];
                end else if (s_valid) begin
                    nxt_d.idle_ok = 1'b1;
                end else if (lpi_req && cur_q.idle_ok) begin
                    nxt_d.st  = ST_LPI;
                    nxt_d.txd = TXD_LPI;
                end else begin
                    nxt_d.idle_ok = 1'b1;
                end
            end
            ST_SEND: begin
                s_ready = tick && last_dibit && !cur_q.eof;
                if (tick) begin
                    if (!last_dibit) begin
                        nxt_d.idx = cur_q.idx + 1'b1;
                        nxt_d.shf = cur_q.shf >> 2;
                        nxt_d.txd = nxt_d.shf[1:0];
                    end else if (s_ready && s_valid) begin
                        nxt_d.shf = s_data;
                        nxt_d.idx = '0;
                        nxt_d.eof = s_eof;
                        nxt_d.txd = s_data[1:0];
                    end else begin
                        nxt_d.st      = ST_IDLE;
                        nxt_d.en      = 1'b0;
                        nxt_d.txd     = TXD_IDLE;
                        nxt_d.idle_ok = 1'b0;
                    end
                end
            end
            ST_LPI: begin
                if (!lpi_req) begin
                    nxt_d.st  = ST_WAKE;
                    nxt_d.txd = TXD_IDLE;
                end
            end
            default: begin
                if (wake_done) begin
                    nxt_d.st      = ST_IDLE;
                    nxt_d.idle_ok = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st      <= ST_IDLE;
            cur_q.shf     <= '0;
            cur_q.idx     <= '0;
            cur_q.eof     <= 1'b0;
            cur_q.idle_ok <= 1'b1;
            cur_q.en      <= 1'b0;
            cur_q.txd     <= TXD_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign txd   = cur_q.txd;
    assign tx_en = cur_q.en;
endmodule

// File: rtl/rmii_lpi_tx_chk.sv
module rmii_lpi_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       s_valid,
    input logic       s_sof,
    input logic       s_ready,
    input logic       lpi_req,
    input logic [1:0] txd,
    input logic       tx_en
);
    logic in_lpi;
    assign in_lpi = !tx_en && (txd == 2'b01);

    // R9
    ready_low_in_lpi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_lpi |-> !s_ready);

    // R7
    lpi_not_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_lpi |-> !$past(tx_en));

    // R8
    no_frame_after_lpi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_lpi |=> !tx_en);

    // R2
    frame_start_needs_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> $past(s_valid && s_ready && s_sof));

    // R5
    idle_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 2'b00 || txd == 2'b01));

    // R8
    lpi_exit_needs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_lpi) && !in_lpi) |-> !$past(lpi_req));
endmodule

bind rmii_lpi_tx rmii_lpi_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_sof   (s_sof),
    .s_ready (s_ready),
    .lpi_req (lpi_req),
    .txd     (txd),
    .tx_en   (tx_en)
);

// File: tb/rmii_lpi_tx_bench.sv
module rmii_lpi_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       speed_slow = 1'b0;
    logic [7:0] wake_cycles = 8'd5;
    logic       lpi_req = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_sof = 1'b0;
    logic       s_eof = 1'b0;
    logic       s_ready;
    logic [1:0] txd;
    logic       tx_en;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    rmii_lpi_tx u_rmii_lpi_tx (
        .clk(clk), .rst_n(rst_n), .speed_slow(speed_slow), .wake_cycles(wake_cycles),
        .lpi_req(lpi_req), .s_valid(s_valid), .s_data(s_data), .s_sof(s_sof),
        .s_eof(s_eof), .s_ready(s_ready), .txd(txd), .tx_en(tx_en)
    );

    // behavioural reference: one queue entry per clock of frame output
    logic [1:0] pend[$];
    logic       m_en, m_ready, m_lpi, m_eof;
    logic [1:0] m_txd;
    int         m_wake, m_idle_run;

    task automatic m_reset();
        pend.delete();
        m_en = 0; m_txd = 2'b00; m_lpi = 0; m_eof = 0;
        m_wake = 0; m_idle_run = 1; m_ready = 1;
    endtask

    task automatic m_load(input logic [7:0] d, input logic e, input int h);
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < h; j++) pend.push_back(d[2*k +: 2]);
        m_eof = e;
        m_en = 1;
        m_txd = pend.pop_front();
    endtask

    function automatic logic m_calc_ready();
        if (m_lpi || m_wake > 0) return 1'b0;
        if (m_en) return (pend.size() == 0) && !m_eof;
        return 1'b1;
    endfunction

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            int  h;
            logic acc;
            h = speed_slow ? 10 : 1;
            acc = s_valid && m_ready;
            if (m_en) begin
                if (pend.size() != 0) m_txd = pend.pop_front();
                else if (acc) m_load(s_data, s_eof, h);
                else begin m_en = 0; m_txd = 2'b00; m_idle_run = 0; end
            end else if (m_lpi) begin
                if (!lpi_req) begin
                    m_lpi = 0; m_txd = 2'b00;
                    m_wake = (wake_cycles == 0) ? 1 : int'(wake_cycles);
                end
            end else if (m_wake > 0) begin
                m_wake--;
                if (m_wake == 0) m_idle_run = 1;
            end else begin
                if (acc && s_sof) m_load(s_data, s_eof, h);
                else if (s_valid) m_idle_run = 1;
                else if (lpi_req && m_idle_run > 0) begin m_lpi = 1; m_txd = 2'b01; end
                else m_idle_run = 1;
            end
            m_ready = m_calc_ready();
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        check(tx_en === m_en, cur_req, "tx_en", tx_en, m_en);
        check(txd === m_txd, cur_req, "txd", txd, m_txd);
        check(s_ready === m_ready, cur_req, "s_ready", s_ready, m_ready);
    end

    task automatic send_byte(input logic [7:0] d, input logic sof, input logic eof);
        s_valid = 1; s_data = d; s_sof = sof; s_eof = eof;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 0; s_sof = 0; s_eof = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int stall;

    initial begin
        idle(2);
        // R1 reset values
        check(tx_en === 1'b0 && txd === 2'b00 && s_ready === 1'b1, "R1", "reset",
              {tx_en, txd, s_ready}, 4'b0001);
        rst_n = 1;
        idle(2);

        // R2 / R4: three-byte back-to-back frame, sof repeated mid-frame
        cur_req = "R2/R4";
        send_byte(8'hE4, 1, 0);
        check(tx_en === 1'b1 && txd === 2'b00, "R2", "first dibit", txd, 0);
        send_byte(8'h1B, 1, 0);
        send_byte(8'h5A, 0, 1);
        idle(6);

        // R5 underrun: second byte offered late
        cur_req = "R5";
        send_byte(8'hC3, 1, 0);
        idle(6);
        check(tx_en === 1'b0 && txd === 2'b00, "R5", "underrun close", tx_en, 0);
        send_byte(8'h96, 1, 1);
        idle(6);

        // R6 byte without sof while idle
        cur_req = "R6";
        send_byte(8'hFF, 0, 1);
        idle(1);
        check(tx_en === 1'b0 && txd === 2'b00, "R6", "no sof ignored", {tx_en, txd}, 0);
        idle(4);

        // R3 slow rate
        cur_req = "R3";
        speed_slow = 1;
        send_byte(8'h2D, 1, 0);
        send_byte(8'hB1, 0, 1);
        idle(45);
        speed_slow = 0;
        idle(3);

        // R10 frame wins over lpi request
        cur_req = "R10";
        lpi_req = 1;
        send_byte(8'h7E, 1, 1);
        check(tx_en === 1'b1, "R10", "frame first", tx_en, 1);
        // R7 lpi requested during the frame; entry only after idle
        cur_req = "R7";
        idle(8);
        check(tx_en === 1'b0 && txd === 2'b01, "R7", "lpi code", {tx_en, txd}, 1);

        // R9 frame offered during lpi is stalled, R8 wake wait of 5
        cur_req = "R8/R9";
        wake_cycles = 8'd5;
        stall = 0;
        fork
            send_byte(8'h3C, 1, 1);
            begin
                idle(10);
                lpi_req = 0;
            end
            begin
                while (!tx_en) begin @(negedge clk); stall++; end
            end
        join
        check(stall >= 16, "R9", "stall length", stall, 16);
        idle(8);

        // R8 zero wake count behaves as one
        cur_req = "R8";
        wake_cycles = 8'd0;
        lpi_req = 1;
        idle(4);
        check(txd === 2'b01, "R8", "lpi before zero wake", txd, 1);
        lpi_req = 0;
        idle(1);
        check(txd === 2'b00 && s_ready === 1'b0, "R8", "wake clock", {txd, s_ready}, 0);
        send_byte(8'hA5, 1, 1);
        idle(8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule